// File: doc/BRIEF.md
# Edge-Pulse Isolation Channel Codec

This block models one logic channel that crosses a galvanic barrier when only short transition pulses can get across. On the sending side an encoder watches a single logic input. It issues a one-cycle "set" pulse when the input rises and a one-cycle "clear" pulse when it falls. When the input has stayed still for a programmable number of cycles, it resends the current level as a refresh pulse. This keeps the far side correct even when it missed an edge or started late.

On the receiving side a bistable latch takes the pulse pair and holds the last level it was given. A starvation watchdog counts cycles without a valid pulse. When the count runs out, it raises a fault flag and forces the output to the safe level, which is high. The two halves meet at ports, so the integrator wires the pulse lines across the barrier model, or breaks them to test fault handling. The refresh and timeout intervals are parameters in clock cycles, and the timeout must be longer than the refresh interval.

Top module: `pulse_iso_channel`

## Requirements
- R1: When `din` is 1 in a cycle where the last level the encoder sent was 0, `tx_set` is 1 for exactly the following cycle.
- R2: When `din` is 0 in a cycle where the last level the encoder sent was 1, `tx_clr` is 1 for exactly the following cycle.
- R3: `tx_set` and `tx_clr` are never 1 in the same cycle.
- R4: After REFRESH_CYCLES cycles with no pulse, the encoder emits a refresh pulse that matches the current level (`tx_set` for 1, `tx_clr` for 0). With the input held still, this repeats every REFRESH_CYCLES cycles.
- R5: Every transition pulse restarts the refresh interval. The first refresh after an edge pulse comes REFRESH_CYCLES cycles after that pulse.
- R6: A cycle with `rx_set`=1 and `rx_clr`=0 makes `dout` 1 from the next cycle on. `rx_clr`=1 with `rx_set`=0 makes `dout` 0. Between pulses, `dout` holds its value.
- R7: A cycle with `rx_set` and `rx_clr` both 1 is ignored. It does not change the latched level, and it does not restart the watchdog.
- R8: After WATCHDOG_CYCLES consecutive cycles without a valid pulse, `link_fault` becomes 1 and `dout` is forced to 1.
- R9: The next valid pulse clears `link_fault` in the following cycle, and `dout` then takes the level carried by that pulse.
- R10: While `rst_n` is 0: `dout`=1, `link_fault`=0, and both pulse outputs are 0. The encoder takes 1 as its last sent level, so a 0 on `din` at the first clock after reset produces a `tx_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Logic level to be carried across |
| tx_set | output | 1 | Encoder pulse: level is 1 |
| tx_clr | output | 1 | Encoder pulse: level is 0 |
| rx_set | input | 1 | Received set pulse into the decoder |
| rx_clr | input | 1 | Received clear pulse into the decoder |
| dout | output | 1 | Recovered level, forced high on fault |
| link_fault | output | 1 | Pulses have stopped arriving |

## Verification
The bench runs the encoder and decoder back to back through a table of input levels. If the refresh counter did not restart on edges, the refresh pulse would come at the wrong cycle. If the encoder kept no memory of the last level it sent, it would pulse on every cycle or never refresh. The bench then breaks the link and drives the pulse pair by hand. This checks that the timeout fires exactly WATCHDOG_CYCLES after the last valid pulse. A design that let a set-and-clear collision restart the watchdog would time out late, and one that latched the collision would drop `dout`. The bench also confirms that a fault clears only on a real pulse. Finally, a reset with `din` low must give a clear pulse at once; a design that reset its last level to 0 would stay silent.

// File: rtl/pulse_iso_pkg.sv
package pulse_iso_pkg;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_SET  = 2'd1,
    PK_CLR  = 2'd2
  } pulse_kind_e;

  // Counter width able to hold values 0 .. limit-1 (at least one bit).
  function automatic int cnt_width(input int limit);
    return (limit > 2) ? $clog2(limit) : 1;
  endfunction

  // Pulse kind that conveys a given level.
  function automatic pulse_kind_e level_pulse(input logic lvl);
    return lvl ? PK_SET : PK_CLR;
  endfunction

endpackage

// File: rtl/iso_edge_encoder.sv
module iso_edge_encoder
  import pulse_iso_pkg::*;
#(
  parameter int REFRESH_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic set_o,
  output logic clr_o
);

  localparam int CW = cnt_width(REFRESH_CYCLES);
  localparam logic [CW-1:0] IDLE_LAST = CW'(REFRESH_CYCLES - 1);

  logic          last_lvl;
  logic [CW-1:0] idle_cnt;
  pulse_kind_e   kind;

  // Transition takes priority; otherwise refresh when idle interval is spent.
  always_comb begin
    if (din != last_lvl)          kind = level_pulse(din);
    else if (idle_cnt == IDLE_LAST) kind = level_pulse(last_lvl);
    else                          kind = PK_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_lvl <= 1'b1;
      idle_cnt <= '0;
      set_o    <= 1'b0;
      clr_o    <= 1'b0;
    end else begin
      set_o    <= (kind == PK_SET);
      clr_o    <= (kind == PK_CLR);
      last_lvl <= din;
      idle_cnt <= (kind != PK_NONE) ? '0 : idle_cnt + 1'b1;
    end
  end

  // R3: the pulse pair is mutually exclusive
  a_r3_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_o && clr_o));

  // R1: a set pulse only follows a cycle where the input was high
  a_r1_set_follows_high: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |-> $past(din));

  // R2: a clear pulse only follows a cycle where the input was low
  a_r2_clr_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> !$past(din));

  // R4: the idle counter stays inside its interval
  a_r4_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= IDLE_LAST);

endmodule

// File: rtl/iso_bistable.sv
module iso_bistable (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)              q_o <= 1'b1;
    else if (set_i && !clr_i) q_o <= 1'b1;
    else if (clr_i && !set_i) q_o <= 1'b0;
  end

  // R6: a lone set pulse latches a one
  a_r6_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);

  // R6: a lone clear pulse latches a zero
  a_r6_clr_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  // R7: colliding pulses leave the latch alone
  a_r7_collision_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> $stable(q_o));

endmodule

// File: rtl/iso_starve_watchdog.sv
module iso_starve_watchdog
  import pulse_iso_pkg::*;
#(
  parameter int WATCHDOG_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_seen_i,
  output logic fault_o
);

  localparam int WW = cnt_width(WATCHDOG_CYCLES);
  localparam logic [WW-1:0] WAIT_LAST = WW'(WATCHDOG_CYCLES - 1);

  logic [WW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
      fault_o   <= 1'b0;
    end else if (pulse_seen_i) begin
      quiet_cnt <= '0;
      fault_o   <= 1'b0;
    end else if (quiet_cnt == WAIT_LAST) begin
      fault_o   <= 1'b1;
    end else begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  // R8: the fault only rises after a cycle with no valid pulse
  a_r8_rise_on_silence: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> !$past(pulse_seen_i));

  // R9: any valid pulse clears the fault on the next cycle
  a_r9_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_seen_i |=> !fault_o);

endmodule

// File: rtl/pulse_iso_channel.sv
module pulse_iso_channel
  import pulse_iso_pkg::*;
#(
  parameter int REFRESH_CYCLES  = 250,
  parameter int WATCHDOG_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tx_set,
  output logic tx_clr,
  input  logic rx_set,
  input  logic rx_clr,
  output logic dout,
  output logic link_fault
);

  logic rx_valid;
  logic held_lvl;

  iso_edge_encoder #(
    .REFRESH_CYCLES(REFRESH_CYCLES)
  ) u_enc (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .set_o(tx_set),
    .clr_o(tx_clr)
  );

  iso_bistable u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(rx_set),
    .clr_i(rx_clr),
    .q_o  (held_lvl)
  );

  // Only a lone pulse counts as proof of life.
  assign rx_valid = rx_set ^ rx_clr;

  iso_starve_watchdog #(
    .WATCHDOG_CYCLES(WATCHDOG_CYCLES)
  ) u_wdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_seen_i(rx_valid),
    .fault_o     (link_fault)
  );

  assign dout = link_fault | held_lvl;

  // R8: a starved link always presents the safe level
  a_r8_fault_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    link_fault |-> dout);

  // R9: a lone clear pulse yields a low output with no fault
  a_r9_clr_recovers: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && !rx_set) |=> (!dout && !link_fault));

endmodule

// File: tb/pulse_iso_channel_test.sv
`timescale 1ns/1ps
module pulse_iso_channel_test;

  localparam int RC = 6;
  localparam int WC = 15;
  localparam int NV = 21;

  // Each entry: {din, expected tx_set, expected tx_clr, expected dout}
  localparam logic [3:0] VEC [NV] = '{
    4'b1001, 4'b1001, 4'b1001, 4'b1001, 4'b1001,
    4'b1101, 4'b0011, 4'b0000, 4'b1100, 4'b1001,
    4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
    4'b0000, 4'b0010, 4'b0000, 4'b1100, 4'b0011,
    4'b0000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b1;
  logic inject = 1'b0;
  logic inj_set = 1'b0;
  logic inj_clr = 1'b0;
  logic tx_set, tx_clr, dout, link_fault;
  logic rx_set, rx_clr;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign rx_set = inject ? inj_set : tx_set;
  assign rx_clr = inject ? inj_clr : tx_clr;

  pulse_iso_channel #(
    .REFRESH_CYCLES (RC),
    .WATCHDOG_CYCLES(WC)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .tx_set    (tx_set),
    .tx_clr    (tx_clr),
    .rx_set    (rx_set),
    .rx_clr    (rx_clr),
    .dout      (dout),
    .link_fault(link_fault)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic c);
    @(negedge clk);
    inj_set = s;
    inj_clr = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R10 dout in reset", dout, 1'b1);
    check("R10 link_fault in reset", link_fault, 1'b0);
    check("R10 tx_set in reset", tx_set, 1'b0);
    check("R10 tx_clr in reset", tx_clr, 1'b0);

    // Loopback table: R1 R2 R4 R5 R6
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      din = VEC[i][3];
      @(posedge clk);
      #1;
      check($sformatf("R1 tx_set row %0d", i), tx_set, VEC[i][2]);
      check($sformatf("R2 tx_clr row %0d", i), tx_clr, VEC[i][1]);
      check($sformatf("R6 dout row %0d", i), dout, VEC[i][0]);
      check($sformatf("R4 R5 no fault row %0d", i), link_fault, 1'b0);
      @(negedge clk);
    end

    // Break the link and drive the decoder directly
    inject = 1'b1;
    step(1'b0, 1'b1);
    check("R6 clear latches low", dout, 1'b0);
    for (int k = 1; k < WC; k++) begin
      step(1'b0, 1'b0);
      check("R8 no early fault", link_fault, 1'b0);
      check("R6 holds low", dout, 1'b0);
    end
    step(1'b0, 1'b0);
    check("R8 fault on timeout", link_fault, 1'b1);
    check("R8 dout forced high", dout, 1'b1);

    // R7: collision does not clear the fault
    step(1'b1, 1'b1);
    check("R7 collision keeps fault", link_fault, 1'b1);
    check("R7 collision keeps dout", dout, 1'b1);

    // R9: lone clear recovers and applies its level
    step(1'b0, 1'b1);
    check("R9 fault cleared", link_fault, 1'b0);
    check("R9 clear level applied", dout, 1'b0);

    // R7: collision does not flip the latch nor restart the watchdog
    step(1'b1, 1'b1);
    check("R7 collision keeps low", dout, 1'b0);
    for (int k = 2; k < WC; k++) begin
      step(1'b0, 1'b0);
      check("R7 no restart early", link_fault, 1'b0);
    end
    step(1'b0, 1'b0);
    check("R7 timeout not restarted by collision", link_fault, 1'b1);

    // R9: set pulse during fault
    step(1'b1, 1'b0);
    check("R9 set clears fault", link_fault, 1'b0);
    check("R9 set level applied", dout, 1'b1);
    step(1'b0, 1'b1);
    check("R6 clear after set", dout, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b0);
      check("R6 hold between pulses", dout, 1'b0);
    end

    // R10: reset with a low input gives a clear pulse at once
    @(negedge clk);
    rst_n = 1'b0;
    inject = 1'b0;
    din = 1'b0;
    @(posedge clk);
    #1;
    check("R10 reset restores dout", dout, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R10 clear after reset", tx_clr, 1'b1);
    check("R10 no set after reset", tx_set, 1'b0);
    @(posedge clk);
    #1;
    check("R10 loopback low", dout, 1'b0);
    check("R3 single pulse width", tx_clr, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule